// File: doc/BRIEF.md
# Triple-Redundant Tile Pool Recovery Controller

This block supervises a pool of identical processor tiles. Three of them run in lockstep as a redundant group and the others wait as spares. Each cycle it picks the three active output words from the pool, forms a bitwise majority word, and, when all three active tiles present valid data and exactly one of them disagrees with the other two, names the disagreeing group slot.

A detected fault starts an escalating recovery on the offending slot. First the tile is held in reset and then readmitted once it acknowledges that it has resynchronized. If it disagrees again soon afterwards, the controller asks an external agent to rewrite that tile's configuration, and then resynchronizes the tile again. If the tile still disagrees after that, or the rewrite request goes unanswered, the tile is retired for good. The lowest-numbered healthy idle tile takes its place in the group and is itself resynchronized. If no spare is left, the group carries on with its two remaining members and a sticky degraded flag is raised.

Only one slot is under recovery at a time. While a tile is being recovered it is left out of the vote.

Top module: `tmr_spare_pool`

## Requirements
- R1: A synchronous reset places tile s in group slot s for s = 0, 1, 2. Slot s appears in `activeSet[4s+3:4s]`. After reset `healthMap` is all ones (bit t = 1 means tile t is usable), `degraded` is 0, and no `tileReset` bit and no `cfgReq` is asserted.
- R2: While all three slots take part in the vote, `votedWord` is the bitwise majority of the three active tiles' words. `votedValid` is 1 only when every participating slot's tile has its valid bit high.
- R3: A fault is declared only when all three slots take part and all three tiles are valid in the same cycle, and exactly one slot's word differs from the other two, which are equal. `faultFlags` bit s is then 1 for the odd slot s. Without such a fault no recovery starts.
- R4: The cycle after a first fault on a slot, that slot's tile receives `tileReset` high for exactly RESET_CYCLES consecutive cycles.
- R5: From the fault until the tile's `syncAck` bit is seen, that slot is left out of the vote. During that time no fault is flagged, `votedValid` needs only the other two valid bits, and `votedWord` is the word of the lowest-numbered participating slot.
- R6: A second fault on the same slot within REPEAT_WIN cycles after the acknowledge raises `cfgReq`, with `cfgTile` holding that tile's index. A fault after the window has elapsed starts a fresh resync instead.
- R7: `cfgReq` and `cfgTile` hold steady until `cfgDone` is seen. The cycle after `cfgDone`, the tile receives a new reset pulse and goes through the R4/R5 resync again.
- R8: If `cfgDone` does not arrive while `cfgReq` has been high for CFG_TIMEOUT cycles, `cfgReq` drops and the tile is retired as in R9.
- R9: A fault on the slot within REPEAT_WIN cycles after the post-reconfiguration resync retires the tile and clears its `healthMap` bit. The slot takes the lowest-index tile that is neither active nor retired, and that tile is then resynchronized as in R4.
- R10: A retired tile never becomes active again and its `healthMap` bit only returns on reset. Every tile in a live slot is marked healthy.
- R11: If no spare exists when a tile is retired, that slot is dropped and `degraded` becomes 1 and stays 1 until reset. With two slots left, no fault is ever flagged and `votedValid` follows the two remaining tiles.
- R12: At most one `tileReset` bit is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tileWords | input | NUM_TILES*DATA_W | Output word of tile t at bits [t*DATA_W +: DATA_W] |
| tileValid | input | NUM_TILES | Per-tile word valid |
| syncAck | input | NUM_TILES | Per-tile resynchronization acknowledge |
| cfgDone | input | 1 | Configuration rewrite finished |
| tileReset | output | NUM_TILES | Per-tile reset |
| cfgReq | output | 1 | Configuration rewrite request |
| cfgTile | output | IDX_W | Tile index for the rewrite request |
| votedWord | output | DATA_W | Majority output word |
| votedValid | output | 1 | Voted word is valid |
| faultFlags | output | 3 | One-hot slot that disagrees |
| activeSet | output | 3*IDX_W | Tile index held by each group slot |
| healthMap | output | NUM_TILES | Usable-tile map |
| degraded | output | 1 | Sticky flag: group reduced to two members |

## Verification
The assertions assume a well-behaved pool. `syncAck` is pulsed only for the tile currently waiting in resync, `cfgDone` is pulsed only while `cfgReq` is high, and reset is applied before the first edge that counts. The stimulus keeps to these rules because acknowledges and completions are issued only from bench tasks that first observe the matching `tileReset` pulse or `cfgReq`. Faults are injected as single-cycle disagreements from one tile while all other words are equal, so exactly one slot is ever the odd one out.

// File: rtl/tmr_pool_pkg.sv
package tmr_pool_pkg;

  // Strobes from the recovery control to the pool datapath
  typedef struct packed {
    logic       hold;    // slot excluded from the vote
    logic       retire;  // retire the slot's tile this cycle
    logic [1:0] slot;    // group slot under recovery
  } poolCmd_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RST,
    ST_ACK,
    ST_WATCH,
    ST_CFG,
    ST_SWAP
  } recState_t;

endpackage

// File: rtl/tmr_pool_datapath.sv
module tmr_pool_datapath
  import tmr_pool_pkg::*;
#(
  parameter int NUM_TILES = 16,
  parameter int DATA_W    = 32,
  parameter int IDX_W     = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [NUM_TILES*DATA_W-1:0] tileWords,
  input  logic [NUM_TILES-1:0]    tileValid,
  input  poolCmd_t                cmd,
  output logic [DATA_W-1:0]       votedWord,
  output logic                    votedValid,
  output logic [2:0]              faultFlags,
  output logic                    mismatch,
  output logic [1:0]              mismatchSlot,
  output logic [IDX_W-1:0]        targetTile,
  output logic                    spareFound,
  output logic [3*IDX_W-1:0]      activeSet,
  output logic [NUM_TILES-1:0]    healthMap,
  output logic                    degraded
);

  localparam int SLOTS = 3;

  logic [IDX_W-1:0]  activeIdx [SLOTS];
  logic [SLOTS-1:0]  deadSlot;
  logic [DATA_W-1:0] slotWord  [SLOTS];
  logic [SLOTS-1:0]  slotValid;
  logic [SLOTS-1:0]  included;
  logic [NUM_TILES-1:0] isActive;
  logic [IDX_W-1:0]  spareIdx;
  logic [DATA_W-1:0] majWord;
  logic              eq01, eq02, eq12;

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    assign slotWord[s]  = tileWords[int'(activeIdx[s])*DATA_W +: DATA_W];
    assign slotValid[s] = tileValid[activeIdx[s]];
    assign included[s]  = !deadSlot[s] && !(cmd.hold && cmd.slot == 2'(s));
    assign activeSet[s*IDX_W +: IDX_W] = activeIdx[s];
  end

  assign majWord = (slotWord[0] & slotWord[1]) | (slotWord[0] & slotWord[2]) |
                   (slotWord[1] & slotWord[2]);
  assign eq01 = (slotWord[0] == slotWord[1]);
  assign eq02 = (slotWord[0] == slotWord[2]);
  assign eq12 = (slotWord[1] == slotWord[2]);

  // Odd-one-out detection, full group only
  always_comb begin
    faultFlags = '0;
    if ((&included) && (&slotValid) && !(eq01 && eq12)) begin
      if (eq01)      faultFlags = 3'b100;
      else if (eq02) faultFlags = 3'b010;
      else if (eq12) faultFlags = 3'b001;
    end
  end

  assign mismatch     = |faultFlags;
  assign mismatchSlot = faultFlags[2] ? 2'd2 : (faultFlags[1] ? 2'd1 : 2'd0);

  always_comb begin
    if (&included)        votedWord = majWord;
    else if (included[0]) votedWord = slotWord[0];
    else if (included[1]) votedWord = slotWord[1];
    else                  votedWord = slotWord[2];
    votedValid = ($countones(included) >= 2) && ((slotValid | ~included) == 3'b111);
  end

  always_comb begin
    isActive = '0;
    for (int s = 0; s < SLOTS; s++) isActive[activeIdx[s]] = 1'b1;
  end

  // Lowest-index healthy idle tile
  always_comb begin
    spareFound = 1'b0;
    spareIdx   = '0;
    for (int t = NUM_TILES - 1; t >= 0; t--) begin
      if (healthMap[t] && !isActive[t]) begin
        spareFound = 1'b1;
        spareIdx   = IDX_W'(t);
      end
    end
  end

  assign targetTile = activeIdx[cmd.slot];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < SLOTS; s++) activeIdx[s] <= IDX_W'(s);
      healthMap <= '1;
      deadSlot  <= '0;
      degraded  <= 1'b0;
    end else if (cmd.retire) begin
      healthMap[targetTile] <= 1'b0;
      if (spareFound) begin
        activeIdx[cmd.slot] <= spareIdx;
      end else begin
        deadSlot[cmd.slot] <= 1'b1;
        degraded           <= 1'b1;
      end
    end
  end

  // Checks
  assert_flags_onehot_R3: assert property (@(posedge clk) disable iff (rst)
    $onehot0(faultFlags));

  assert_hold_silent_R5: assert property (@(posedge clk) disable iff (rst)
    cmd.hold |-> (faultFlags == 3'b000));

  assert_retire_clears_R9: assert property (@(posedge clk) disable iff (rst)
    cmd.retire |=> !healthMap[$past(targetTile)]);

  assert_health_monotonic_R10: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((healthMap & ~$past(healthMap)) == '0));

  assert_degraded_sticky_R11: assert property (@(posedge clk) disable iff (rst)
    degraded |=> degraded);

  for (genvar s = 0; s < SLOTS; s++) begin : g_chk
    assert_live_healthy_R10: assert property (@(posedge clk) disable iff (rst)
      !deadSlot[s] |-> healthMap[activeIdx[s]]);
  end

endmodule

// File: rtl/tmr_pool_ctrl.sv
module tmr_pool_ctrl
  import tmr_pool_pkg::*;
#(
  parameter int NUM_TILES    = 16,
  parameter int IDX_W        = 4,
  parameter int RESET_CYCLES = 8,
  parameter int REPEAT_WIN   = 256,
  parameter int CFG_TIMEOUT  = 1024
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 mismatch,
  input  logic [1:0]           mismatchSlot,
  input  logic [IDX_W-1:0]     targetTile,
  input  logic                 spareFound,
  input  logic [NUM_TILES-1:0] syncAck,
  input  logic                 cfgDone,
  output poolCmd_t             cmd,
  output logic [NUM_TILES-1:0] tileReset,
  output logic                 cfgReq,
  output logic [IDX_W-1:0]     cfgTile
);

  localparam int MAX_AB  = (RESET_CYCLES > REPEAT_WIN) ? RESET_CYCLES : REPEAT_WIN;
  localparam int CNT_MAX = (MAX_AB > CFG_TIMEOUT) ? MAX_AB : CFG_TIMEOUT;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);

  recState_t        state;
  logic [1:0]       slotR;
  logic             stage;   // 1 once the tile has been reconfigured
  logic [CNT_W-1:0] cnt;

  assign cmd.slot   = slotR;
  assign cmd.hold   = (state == ST_RST) || (state == ST_ACK) || (state == ST_CFG);
  assign cmd.retire = (state == ST_SWAP);
  assign cfgReq     = (state == ST_CFG);
  assign cfgTile    = targetTile;

  always_comb begin
    tileReset = '0;
    if (state == ST_RST) tileReset[targetTile] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      slotR <= '0;
      stage <= 1'b0;
      cnt   <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (mismatch) begin
            slotR <= mismatchSlot;
            stage <= 1'b0;
            cnt   <= '0;
            state <= ST_RST;
          end
        end
        ST_RST: begin
          if (cnt == CNT_W'(RESET_CYCLES - 1)) begin
            cnt   <= '0;
            state <= ST_ACK;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_ACK: begin
          if (syncAck[targetTile]) begin
            cnt   <= '0;
            state <= ST_WATCH;
          end
        end
        ST_WATCH: begin
          if (mismatch && mismatchSlot == slotR) begin
            cnt   <= '0;
            state <= stage ? ST_SWAP : ST_CFG;
          end else if (mismatch) begin
            slotR <= mismatchSlot;
            stage <= 1'b0;
            cnt   <= '0;
            state <= ST_RST;
          end else if (cnt == CNT_W'(REPEAT_WIN - 1)) begin
            cnt   <= '0;
            state <= ST_IDLE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_CFG: begin
          if (cfgDone) begin
            stage <= 1'b1;
            cnt   <= '0;
            state <= ST_RST;
          end else if (cnt == CNT_W'(CFG_TIMEOUT - 1)) begin
            cnt   <= '0;
            state <= ST_SWAP;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_SWAP: begin
          stage <= 1'b0;
          cnt   <= '0;
          state <= spareFound ? ST_RST : ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // Checks
  assert_one_reset_R12: assert property (@(posedge clk) disable iff (rst)
    $onehot0(tileReset));

  assert_fault_starts_reset_R4: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE && mismatch) |=> (tileReset != '0));

  assert_cfg_index_stable_R7: assert property (@(posedge clk) disable iff (rst)
    (cfgReq && $past(cfgReq)) |-> $stable(cfgTile));

  assert_cfg_done_resync_R7: assert property (@(posedge clk) disable iff (rst)
    (cfgReq && cfgDone) |=> (tileReset != '0));

endmodule

// File: rtl/tmr_spare_pool.sv
module tmr_spare_pool
  import tmr_pool_pkg::*;
#(
  parameter int NUM_TILES    = 16,
  parameter int DATA_W       = 32,
  parameter int RESET_CYCLES = 8,
  parameter int REPEAT_WIN   = 256,
  parameter int CFG_TIMEOUT  = 1024,
  localparam int IDX_W       = $clog2(NUM_TILES)
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [NUM_TILES*DATA_W-1:0] tileWords,
  input  logic [NUM_TILES-1:0]        tileValid,
  input  logic [NUM_TILES-1:0]        syncAck,
  input  logic                        cfgDone,
  output logic [NUM_TILES-1:0]        tileReset,
  output logic                        cfgReq,
  output logic [IDX_W-1:0]            cfgTile,
  output logic [DATA_W-1:0]           votedWord,
  output logic                        votedValid,
  output logic [2:0]                  faultFlags,
  output logic [3*IDX_W-1:0]          activeSet,
  output logic [NUM_TILES-1:0]        healthMap,
  output logic                        degraded
);

  poolCmd_t         cmd;
  logic             mismatch;
  logic [1:0]       mismatchSlot;
  logic [IDX_W-1:0] targetTile;
  logic             spareFound;

  tmr_pool_datapath #(
    .NUM_TILES(NUM_TILES), .DATA_W(DATA_W), .IDX_W(IDX_W)
  ) datapath_i (
    .clk(clk), .rst(rst), .tileWords(tileWords), .tileValid(tileValid), .cmd(cmd),
    .votedWord(votedWord), .votedValid(votedValid), .faultFlags(faultFlags),
    .mismatch(mismatch), .mismatchSlot(mismatchSlot), .targetTile(targetTile),
    .spareFound(spareFound), .activeSet(activeSet), .healthMap(healthMap),
    .degraded(degraded)
  );

  tmr_pool_ctrl #(
    .NUM_TILES(NUM_TILES), .IDX_W(IDX_W), .RESET_CYCLES(RESET_CYCLES),
    .REPEAT_WIN(REPEAT_WIN), .CFG_TIMEOUT(CFG_TIMEOUT)
  ) ctrl_i (
    .clk(clk), .rst(rst), .mismatch(mismatch), .mismatchSlot(mismatchSlot),
    .targetTile(targetTile), .spareFound(spareFound), .syncAck(syncAck),
    .cfgDone(cfgDone), .cmd(cmd), .tileReset(tileReset), .cfgReq(cfgReq),
    .cfgTile(cfgTile)
  );

endmodule

// File: tb/tmr_spare_pool_tb.sv
module tmr_spare_pool_tb_top;

  localparam int NT = 16;
  localparam int DW = 8;
  localparam int RC = 3;
  localparam int RW = 8;
  localparam int CT = 10;
  localparam int IW = 4;
  localparam logic [DW-1:0] BASE = 8'hC3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [DW-1:0] w [NT];
  logic [NT*DW-1:0] tileWords;
  logic [NT-1:0] tileValid = '1;
  logic [NT-1:0] syncAck = '0;
  logic cfgDone = 1'b0;
  logic [NT-1:0] tileReset;
  logic cfgReq;
  logic [IW-1:0] cfgTile;
  logic [DW-1:0] votedWord;
  logic votedValid;
  logic [2:0] faultFlags;
  logic [3*IW-1:0] activeSet;
  logic [NT-1:0] healthMap;
  logic degraded;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  int mAct [3];
  bit mGood [NT];
  bit mDead [3];
  bit mDeg;

  always #2.5 clk = ~clk;

  always_comb begin
    for (int t = 0; t < NT; t++) tileWords[t*DW +: DW] = w[t];
  end

  tmr_spare_pool #(
    .NUM_TILES(NT), .DATA_W(DW), .RESET_CYCLES(RC), .REPEAT_WIN(RW), .CFG_TIMEOUT(CT)
  ) dut_i (
    .clk(clk), .rst(rst), .tileWords(tileWords), .tileValid(tileValid),
    .syncAck(syncAck), .cfgDone(cfgDone), .tileReset(tileReset), .cfgReq(cfgReq),
    .cfgTile(cfgTile), .votedWord(votedWord), .votedValid(votedValid),
    .faultFlags(faultFlags), .activeSet(activeSet), .healthMap(healthMap),
    .degraded(degraded)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] got,
                     input logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: got %0h expected %0h at %0t", req, got, exp, $time);
    end
  endtask

  task automatic modelReset();
    for (int s = 0; s < 3; s++) begin mAct[s] = s; mDead[s] = 1'b0; end
    for (int t = 0; t < NT; t++) mGood[t] = 1'b1;
    mDeg = 1'b0;
  endtask

  task automatic setAll();
    for (int t = 0; t < NT; t++) w[t] = BASE;
    tileValid = '1;
  endtask

  task automatic checkState(input string req);
    logic [NT-1:0] hm;
    for (int t = 0; t < NT; t++) hm[t] = mGood[t];
    chk(healthMap == hm, req, healthMap, hm);
    for (int s = 0; s < 3; s++) begin
      if (!mDead[s]) begin
        chk(activeSet[s*IW +: IW] == IW'(mAct[s]), req, activeSet[s*IW +: IW], mAct[s]);
        chk(mGood[mAct[s]], req, 0, 1);
      end
    end
    chk(degraded == mDeg, req, degraded, mDeg);
  endtask

  // One-cycle disagreement from the tile in the given slot
  task automatic inject(input int slot);
    w[mAct[slot]] = BASE ^ 8'h5A;
    #1;
    chk(faultFlags == 3'(1 << slot), "R3 fault slot", faultFlags, 3'(1 << slot));
    @(negedge clk);
    w[mAct[slot]] = BASE;
  endtask

  task automatic resyncTile(input int t, input string req);
    int n;
    for (int k = 0; k < 6; k++) if (!tileReset[t]) @(negedge clk);
    chk(tileReset[t] == 1'b1, {req, " reset start"}, tileReset, NT'(1) << t);
    n = 0;
    while (tileReset[t] && n < 50) begin n++; @(negedge clk); end
    chk(n == RC, "R4 reset length", n, RC);
    w[t] = BASE ^ 8'h33;
    #1;
    chk(faultFlags == 3'b000, "R5 excluded tile flags", faultFlags, 0);
    chk(votedValid == 1'b1, "R5 voted valid", votedValid, 1);
    chk(votedWord == BASE, "R5 voted word", votedWord, BASE);
    @(negedge clk);
    chk(tileReset == '0, "R5 waits for ack", tileReset, 0);
    w[t] = BASE;
    syncAck[t] = 1'b1;
    @(negedge clk);
    syncAck[t] = 1'b0;
  endtask

  task automatic cfgPhase(input int t, input bit answer);
    int n;
    chk(cfgReq == 1'b1, "R6 cfg request", cfgReq, 1);
    chk(cfgTile == IW'(t), "R6 cfg tile", cfgTile, t);
    if (answer) begin
      for (int k = 0; k < 3; k++) begin
        @(negedge clk);
        chk(cfgReq == 1'b1 && cfgTile == IW'(t), "R7 request held", cfgTile, t);
      end
      cfgDone = 1'b1;
      @(negedge clk);
      cfgDone = 1'b0;
    end else begin
      n = 0;
      while (cfgReq && n < 100) begin n++; @(negedge clk); end
      chk(n == CT, "R8 timeout length", n, CT);
    end
  endtask

  function automatic int swapModel(input int slot);
    int pick;
    pick = -1;
    mGood[mAct[slot]] = 1'b0;
    for (int t = NT - 1; t >= 0; t--) begin
      if (mGood[t] && t != mAct[0] && t != mAct[1] && t != mAct[2]) pick = t;
    end
    if (pick >= 0) mAct[slot] = pick;
    else begin mDead[slot] = 1'b1; mDeg = 1'b1; end
    return pick;
  endfunction

  task automatic killSlot(input int slot);
    int t, nt;
    t = mAct[slot];
    inject(slot);
    resyncTile(t, "R4");
    inject(slot);
    cfgPhase(t, 1'b0);
    nt = swapModel(slot);
    if (nt >= 0) resyncTile(nt, "R9");
    else begin @(negedge clk); @(negedge clk); end
    checkState(nt >= 0 ? "R10 spare choice" : "R11 degraded");
    repeat (RW + 2) @(negedge clk);
  endtask

  initial begin
    int nt;
    logic [DW-1:0] a, b, c, maj;
    modelReset();
    setAll();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    checkState("R1 reset state");
    chk(tileReset == '0 && cfgReq == 1'b0, "R1 idle outputs", {tileReset, cfgReq}, 0);

    // R2 majority sweep with slot 2 invalid (no fault may be declared)
    tileValid[2] = 1'b0;
    for (int i = 0; i < 8; i++) begin
      for (int j = 0; j < 8; j++) begin
        for (int k = 0; k < 8; k++) begin
          a = DW'(i * 37 + 5); b = DW'(j * 71 + 9); c = DW'(k * 113 + 3);
          w[0] = a; w[1] = b; w[2] = c;
          #1;
          maj = (a & b) | (a & c) | (b & c);
          chk(votedWord == maj, "R2 majority", votedWord, maj);
          chk(votedValid == 1'b0, "R2 valid gating", votedValid, 0);
          chk(faultFlags == 3'b000, "R3 needs all valid", faultFlags, 0);
          @(negedge clk);
        end
      end
    end
    @(negedge clk);
    chk(tileReset == '0 && cfgReq == 1'b0, "R3 no recovery without fault", tileReset, 0);
    setAll();
    #1;
    chk(votedValid == 1'b1 && votedWord == BASE, "R2 agreeing group", votedWord, BASE);
    @(negedge clk);

    // Full escalation on slot 1 with an answered reconfiguration
    inject(1);
    resyncTile(1, "R4");
    inject(1);
    cfgPhase(1, 1'b1);
    resyncTile(1, "R7");
    inject(1);
    nt = swapModel(1);
    resyncTile(nt, "R9");
    checkState("R9 swap");
    repeat (RW + 2) @(negedge clk);

    // Window boundaries and timeout on slot 0
    inject(0);
    resyncTile(0, "R4");
    repeat (RW) @(negedge clk);
    inject(0);
    chk(cfgReq == 1'b0, "R6 outside window", cfgReq, 0);
    resyncTile(0, "R6");
    repeat (RW - 1) @(negedge clk);
    inject(0);
    cfgPhase(0, 1'b0);
    nt = swapModel(0);
    resyncTile(nt, "R8");
    checkState("R8 retire on timeout");
    repeat (RW + 2) @(negedge clk);

    // Exhaust the spare pool through slot 0
    for (int r = 0; r < 12; r++) killSlot(0);
    chk(degraded == 1'b1, "R11 degraded raised", degraded, 1);

    // Two-member group: no fault declared
    w[mAct[1]] = BASE ^ 8'h01;
    #1;
    chk(faultFlags == 3'b000, "R11 no fault with two", faultFlags, 0);
    chk(votedValid == 1'b1, "R11 two-member valid", votedValid, 1);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk(tileReset == '0 && cfgReq == 1'b0, "R11 no recovery", tileReset, 0);
    end
    w[mAct[1]] = BASE;
    repeat (5) @(negedge clk);
    chk(degraded == 1'b1, "R11 sticky", degraded, 1);
    chk(tileReset == '0, "R12 quiet", tileReset, 0);

    // Reset mid-run
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    modelReset();
    @(negedge clk);
    checkState("R1 reset after use");

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

endmodule